// File: doc/BRIEF.md
# Bus-Attached Serial Port with Single-Byte Holding Registers

This block is a peripheral on an APB-style register bus that sends and receives bytes over a two-wire asynchronous serial line. The line format is fixed: one low start bit, eight data bits sent least significant bit first, no parity, and one high stop bit. Each direction has a single one-byte holding register. Software writes a byte to send it and reads a byte once one has arrived. A status register reports whether each holding register is full and whether an overrun occurred.

Bit timing comes from a divider register. Every serial bit lasts that many clock cycles. A divider value below 16 is invalid, and while it is invalid the line logic does nothing. Four interrupt lines report transmit done, receive ready, transmit overrun and receive overrun. A fifth line is the OR of those four. A small read-only identification window sits at the top of the 4 KiB register space.

Top module: `apb_serial_port`

## Requirements
- R1: After reset, every register reads zero, txd is high and all five interrupt lines are low.
- R2: The configuration register at offset 0x08 keeps only bits 6:0. The divider register at offset 0x10 keeps only bits 19:0. A read from an offset that decodes to nothing returns zero.
- R3: The identification window has twelve words at offsets 0xFD0 to 0xFFC. Word k, at offset 0xFD0+4k, reads as 0x40+k in bits 7:0 with all higher bits zero. Writes to the window change nothing.
- R4: Status is at offset 0x04. A write to the data register (offset 0x00) while status bit 0 (transmit full) is clear sets that bit. A write while status bit 0 is set replaces the pending byte and sets status bit 2 (transmit overrun).
- R5: Status bits 0 and 1 (receive full) ignore writes. Writing 1 to status bit 2 or bit 3 clears that bit.
- R6: A pending byte moves into the transmitter when all three of these hold: configuration bit 0 (transmit enable) is set, the divider is at least 16, and the transmitter is idle. At that moment status bit 0 clears. If configuration bit 2 is set, interrupt-status bit 0 (offset 0x0C) is also set. On txd the frame is one low start bit, eight data bits LSB first, and one high stop bit, each lasting divider cycles.
- R7: While the divider is below 16, txd stays high, a pending byte stays pending, and frames on rxd are not received.
- R8: With configuration bit 1 (receive enable) set, a complete frame on rxd stores its byte and sets status bit 1. If configuration bit 3 is also set, it sets interrupt-status bit 1. A read of the data register returns the stored byte and clears status bit 1.
- R9: Frames that arrive while configuration bit 1 is clear are dropped. The stored byte and status bit 1 stay unchanged.
- R10: A frame that arrives while status bit 1 is set sets status bit 3 (receive overrun) and overwrites the stored byte.
- R11: Interrupt-status bits 2 and 3 are not stored. They always equal status bit 2 AND configuration bit 4, and status bit 3 AND configuration bit 5. Writing 1 to any interrupt-status bit clears it. For bits 2 and 3 the write clears the matching status bit.
- R12: Each of irq_tx, irq_rx, irq_txovr and irq_rxovr follows interrupt-status bit 0, 1, 2 and 3 respectively. irq_any is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, idles high |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
Faults in the internal state show up at the ports, and the checks are built to catch each kind quickly.

- A wrong holding-register flag appears in the status word on the first read after the bus write or serial frame that should have changed it. A stale flag can also stall a pending byte forever, leaving txd high where a start bit was expected.
- A wrong bit counter or divider reload shifts the mid-bit samples in the captured transmit frame. On the receive side it corrupts the received byte. Either way the error is seen within one frame, which is ten divider periods.
- The overrun interrupt bits are derived live from other registers. A stored copy of them would be exposed by a single change of the enable bit followed by a read.

// File: rtl/usp_pkg.sv
// Package: shared offsets and phase type for the serial port.
// Assumes a 12-bit byte offset space; offsets below are behaviour.
package usp_pkg;
    localparam int OFS_DATA  = 'h000;
    localparam int OFS_STAT  = 'h004;
    localparam int OFS_CFG   = 'h008;
    localparam int OFS_IRQ   = 'h00C;
    localparam int OFS_DIV   = 'h010;
    localparam int OFS_ID_LO = 'hFD0;
    localparam int CFG_W     = 7;
    localparam int CFG_TXEN  = 0;
    localparam int CFG_RXEN  = 1;
    localparam int CFG_TXIE  = 2;
    localparam int CFG_RXIE  = 3;
    localparam int CFG_TOIE  = 4;
    localparam int CFG_ROIE  = 5;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/usp_tx_shift.sv
// Transmit shifter: loads a byte on load_i and plays one frame
// (start, DATA_W bits LSB first, stop), each bit div_i cycles long.
// Assumes div_i is valid while busy and load_i only when idle.
module usp_tx_shift #(
    parameter int DIV_W  = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              txd_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int NB_W    = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [DIV_W-1:0]   cnt;
    logic [NB_W-1:0]    left;

    // Frame sequencing: reload on load, shift once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            shreg  <= '1;
            cnt    <= '0;
            left   <= '0;
        end else if (load_i) begin
            busy_o <= 1'b1;
            shreg  <= {1'b1, byte_i, 1'b0};
            cnt    <= div_i - DIV_W'(1);
            left   <= NB_W'(FRAME_W - 1);
        end else if (busy_o) begin
            if (cnt == '0) begin
                if (left == '0) begin
                    busy_o <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    left  <= left - NB_W'(1);
                    cnt   <= div_i - DIV_W'(1);
                end
            end else begin
                cnt <= cnt - DIV_W'(1);
            end
        end
    end

    // Line level: current frame bit, high when idle.
    always_comb txd_o = busy_o ? shreg[0] : 1'b1;
endmodule

// File: rtl/usp_rx_shift.sv
// Receive shifter: synchronises rxd, finds a start edge, samples each
// bit at its middle and pulses valid_o for one cycle on a good stop bit.
// Assumes en_i is low whenever div_i is invalid.
module usp_rx_shift #(
    parameter int DIV_W  = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              rxd_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] byte_o
);
    import usp_pkg::*;
    localparam int BI_W = $clog2(DATA_W);

    logic [1:0]       sync;
    rx_phase_e        phase;
    logic [DIV_W-1:0] cnt;
    logic [BI_W-1:0]  nbit;
    logic             line;

    always_comb line = sync[1];

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd_i};
    end

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= RX_IDLE;
            cnt     <= '0;
            nbit    <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (phase)
                RX_IDLE: begin
                    if (en_i && !line) begin
                        phase <= RX_START;
                        cnt   <= (div_i >> 1) - DIV_W'(1);
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (!line) begin
                            phase <= RX_BITS;
                            cnt   <= div_i - DIV_W'(1);
                            nbit  <= '0;
                        end else begin
                            phase <= RX_IDLE;
                        end
                    end else cnt <= cnt - DIV_W'(1);
                end
                RX_BITS: begin
                    if (cnt == '0) begin
                        byte_o <= {line, byte_o[DATA_W-1:1]};
                        cnt    <= div_i - DIV_W'(1);
                        if (nbit == BI_W'(DATA_W - 1)) phase <= RX_STOP;
                        else                           nbit  <= nbit + BI_W'(1);
                    end else cnt <= cnt - DIV_W'(1);
                end
                default: begin
                    if (cnt == '0) begin
                        valid_o <= line;
                        phase   <= RX_IDLE;
                    end else cnt <= cnt - DIV_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/apb_serial_port.sv
// Serial port top: register decode, holding registers, sticky flags,
// interrupt outputs, and the two line shifters.
// Assumes ADDR_W is 12 and a zero-wait-state bus (access in one cycle).
module apb_serial_port #(
    parameter int          ADDR_W  = 12,
    parameter int          DIV_W   = 20,
    parameter int          DATA_W  = 8,
    parameter int          MIN_DIV = 16,
    parameter logic [7:0]  ID_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_txovr,
    output logic              irq_rxovr,
    output logic              irq_any
);
    import usp_pkg::*;

    logic [CFG_W-1:0]  cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] tx_hold, rx_hold, rx_byte;
    logic tx_full, rx_full, tx_ovr, rx_ovr, tx_flag, rx_flag;
    logic wr_acc, rd_acc, wr_data_acc, rd_data_acc;
    logic hit_data, hit_stat, hit_cfg, hit_irq, hit_div, hit_id;
    logic baud_ok, tx_busy, tx_load, rx_valid, rx_en;
    logic [3:0] id_idx;
    logic [3:0] irq_vec;

    // Bus access qualifiers and offset decode.
    always_comb begin
        wr_acc      = psel && penable && pwrite;
        rd_acc      = psel && penable && !pwrite;
        hit_data    = paddr == ADDR_W'(OFS_DATA);
        hit_stat    = paddr == ADDR_W'(OFS_STAT);
        hit_cfg     = paddr == ADDR_W'(OFS_CFG);
        hit_irq     = paddr == ADDR_W'(OFS_IRQ);
        hit_div     = paddr == ADDR_W'(OFS_DIV);
        hit_id      = (paddr >= ADDR_W'(OFS_ID_LO)) && (paddr[1:0] == 2'b00);
        id_idx      = paddr[5:2] - 4'(OFS_ID_LO >> 2);
        wr_data_acc = wr_acc && hit_data;
        rd_data_acc = rd_acc && hit_data;
    end

    // Divider validity, transmit hand-off and receive gating.
    always_comb begin
        baud_ok = div_q >= DIV_W'(MIN_DIV);
        tx_load = tx_full && cfg_q[CFG_TXEN] && baud_ok && !tx_busy;
        rx_en   = cfg_q[CFG_RXEN];
    end

    // Configuration and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (wr_acc) begin
            if (hit_cfg) cfg_q <= pwdata[CFG_W-1:0];
            if (hit_div) div_q <= pwdata[DIV_W-1:0];
        end
    end

    // Transmit holding register, full flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
            tx_ovr  <= 1'b0;
        end else begin
            if (tx_load) tx_full <= 1'b0;
            if (wr_acc && hit_stat && pwdata[2]) tx_ovr <= 1'b0;
            if (wr_acc && hit_irq && pwdata[2])  tx_ovr <= 1'b0;
            if (wr_data_acc) begin
                tx_hold <= pwdata[DATA_W-1:0];
                tx_full <= 1'b1;
                if (tx_full) tx_ovr <= 1'b1;
            end
        end
    end

    // Receive holding register, full flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            if (wr_acc && hit_stat && pwdata[3]) rx_ovr <= 1'b0;
            if (wr_acc && hit_irq && pwdata[3])  rx_ovr <= 1'b0;
            if (rx_valid && rx_en) begin
                rx_hold <= rx_byte;
                rx_full <= 1'b1;
                if (rx_full) rx_ovr <= 1'b1;
            end else if (rd_data_acc) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Sticky transmit/receive interrupt flags; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (wr_acc && hit_irq && pwdata[0]) tx_flag <= 1'b0;
            if (wr_acc && hit_irq && pwdata[1]) rx_flag <= 1'b0;
            if (tx_load && cfg_q[CFG_TXIE]) tx_flag <= 1'b1;
            if (rx_valid && rx_en && cfg_q[CFG_RXIE]) rx_flag <= 1'b1;
        end
    end

    // Interrupt status word: overrun bits are live products.
    always_comb begin
        irq_vec   = {rx_ovr && cfg_q[CFG_ROIE], tx_ovr && cfg_q[CFG_TOIE],
                     rx_flag, tx_flag};
        irq_tx    = irq_vec[0];
        irq_rx    = irq_vec[1];
        irq_txovr = irq_vec[2];
        irq_rxovr = irq_vec[3];
        irq_any   = |irq_vec;
    end

    // Read data multiplexer.
    always_comb begin
        prdata = '0;
        if (hit_data)      prdata = 32'(rx_hold);
        else if (hit_stat) prdata = {28'b0, rx_ovr, tx_ovr, rx_full, tx_full};
        else if (hit_cfg)  prdata = 32'(cfg_q);
        else if (hit_irq)  prdata = {28'b0, irq_vec};
        else if (hit_div)  prdata = 32'(div_q);
        else if (hit_id)   prdata = {24'b0, ID_BASE + 8'(id_idx)};
    end

    usp_tx_shift #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tx_load),
        .byte_i (tx_hold),
        .div_i  (div_q),
        .busy_o (tx_busy),
        .txd_o  (txd)
    );

    usp_rx_shift #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (baud_ok),
        .div_i   (div_q),
        .rxd_i   (rxd),
        .valid_o (rx_valid),
        .byte_o  (rx_byte)
    );
endmodule

// File: rtl/usp_checker.sv
// Property checker for the serial port, attached by bind below.
// Assumes the internal signal names of apb_serial_port.
module usp_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_data_acc,
    input logic rd_data_acc,
    input logic tx_full,
    input logic tx_ovr,
    input logic rx_full,
    input logic rx_ovr,
    input logic rx_valid,
    input logic rx_en,
    input logic baud_ok,
    input logic tx_busy,
    input logic txd,
    input logic irq_tx
);
    // R4: data write onto a full transmit register flags overrun
    a_r4_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_acc && tx_full |=> tx_ovr);

    // R8: reading data with no simultaneous arrival empties the buffer
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_acc && !(rx_valid && rx_en) |=> !rx_full);

    // R10: arrival onto a full receive register flags overrun
    a_r10_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_en && rx_full |=> rx_ovr && rx_full);

    // R7: invalid divider and idle shifter keep the line high
    a_r7_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_ok && !tx_busy |-> txd);

    // R6: transmit interrupt rises only when a pending byte was taken
    a_r6_tx_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> $past(tx_full));
endmodule

bind apb_serial_port usp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_acc (wr_data_acc),
    .rd_data_acc (rd_data_acc),
    .tx_full     (tx_full),
    .tx_ovr      (tx_ovr),
    .rx_full     (rx_full),
    .rx_ovr      (rx_ovr),
    .rx_valid    (rx_valid),
    .rx_en       (rx_en),
    .baud_ok     (baud_ok),
    .tx_busy     (tx_busy),
    .txd         (txd),
    .irq_tx      (irq_tx)
);

// File: tb/sim_apb_serial_port.sv
module sim_apb_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;
    localparam int NVEC       = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        txd, rxd = 1'b1;
    logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
    int          total = 0, bad = 0;
    logic [31:0] rv;
    logic [7:0]  tb_byte;

    // Vector: {is_write, offset, data-or-expected}
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b1, 12'h008, 32'hFFFF_FFFF},  // R2 cfg write
        {1'b0, 12'h008, 32'h0000_007F},  // R2 7 bits kept
        {1'b1, 12'h010, 32'hFFFF_FFFF},  // R2 div write
        {1'b0, 12'h010, 32'h000F_FFFF},  // R2 20 bits kept
        {1'b0, 12'h014, 32'h0000_0000},  // R2 undecoded
        {1'b0, 12'hFD0, 32'h0000_0040},  // R3 word 0
        {1'b0, 12'hFFC, 32'h0000_004B},  // R3 word 11
        {1'b1, 12'hFE0, 32'h0000_0000},  // R3 write ignored
        {1'b0, 12'hFE0, 32'h0000_0044},  // R3 word 4
        {1'b1, 12'h004, 32'h0000_000F},  // R5 status write
        {1'b0, 12'h004, 32'h0000_0000},  // R5 read-only bits stay 0
        {1'b1, 12'h008, 32'h0000_0000},
        {1'b0, 12'h008, 32'h0000_0000},
        {1'b1, 12'h010, 32'h0000_0000},
        {1'b0, 12'h010, 32'h0000_0000}
    };

    apb_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a,
                            input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    // Drives one 8N1 frame on rxd, then idles high.
    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2*BIT_CYC) @(negedge clk);
    endtask

    // Captures one frame from txd with mid-bit sampling.
    task automatic get_tx(input string tag, output logic [7:0] b);
        int waited = 0;
        b = '0;
        while (txd !== 1'b0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (BIT_CYC/2) @(negedge clk);
        check({tag, " start bit"}, {31'b0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT_CYC) @(negedge clk);
        check({tag, " stop bit"}, {31'b0, txd}, 32'h1);
        repeat (BIT_CYC) @(negedge clk);
    endtask

    function automatic logic [31:0] irqs();
        return {27'b0, irq_any, irq_rxovr, irq_txovr, irq_rx, irq_tx};
    endfunction

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 txd idle", {31'b0, txd}, 32'h1);
        check("R1 irq lines", irqs(), 32'h0);
        rd_check("R1 status", 12'h004, 32'h0);
        rd_check("R1 cfg", 12'h008, 32'h0);
        rd_check("R1 irq status", 12'h00C, 32'h0);
        rd_check("R1 divider", 12'h010, 32'h0);
        rd_check("R1 data", 12'h000, 32'h0);

        // R2/R3/R5 register table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][44]) bus_wr(VEC[i][43:32], VEC[i][31:0]);
            else begin
                bus_rd(VEC[i][43:32], rv);
                check($sformatf("R2/R3/R5 vector %0d", i), rv, VEC[i][31:0]);
            end
        end

        // R7: invalid divider keeps the byte pending and the line high
        bus_wr(12'h010, 32'd4);
        bus_wr(12'h008, 32'h01);
        bus_wr(12'h000, 32'h3C);
        lows = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R7 txd quiet", lows, 0);
        rd_check("R7 still pending", 12'h004, 32'h1);

        // R4: second write overruns
        bus_wr(12'h000, 32'hC3);
        rd_check("R4 tx overrun", 12'h004, 32'h5);

        // R11/R12: live overrun interrupt
        bus_wr(12'h008, 32'h10);
        rd_check("R11 txo visible", 12'h00C, 32'h4);
        check("R12 txo lines", irqs(), 32'h14);
        bus_wr(12'h008, 32'h00);
        rd_check("R11 txo masked", 12'h00C, 32'h0);
        check("R12 lines masked", irqs(), 32'h0);
        bus_wr(12'h008, 32'h10);
        bus_wr(12'h00C, 32'h4);
        rd_check("R11 clears status", 12'h004, 32'h1);
        rd_check("R11 irq cleared", 12'h00C, 32'h0);

        // R6: transmit the overwritten byte
        bus_wr(12'h010, BIT_CYC);
        bus_wr(12'h008, 32'h05);
        get_tx("R6 frame", tb_byte);
        check("R6 byte sent (R4 overwrite)", tb_byte, 32'hC3);
        rd_check("R6 full cleared", 12'h004, 32'h0);
        rd_check("R6 tx flag", 12'h00C, 32'h1);
        check("R12 irq_tx", irqs(), 32'h11);
        bus_wr(12'h00C, 32'h1);
        rd_check("R11 tx flag W1C", 12'h00C, 32'h0);
        bus_wr(12'h000, 32'h5A);
        get_tx("R6 frame 2", tb_byte);
        check("R6 second byte", tb_byte, 32'h5A);

        // R8: receive
        bus_wr(12'h00C, 32'h1);
        bus_wr(12'h008, 32'h0A);
        send_rx(8'h96);
        rd_check("R8 rx full", 12'h004, 32'h2);
        rd_check("R8 rx flag", 12'h00C, 32'h2);
        check("R12 irq_rx", irqs(), 32'h12);
        rd_check("R8 data", 12'h000, 32'h96);
        rd_check("R8 full cleared", 12'h004, 32'h0);
        bus_wr(12'h00C, 32'h2);

        // R10: receive overrun
        send_rx(8'h11);
        send_rx(8'h22);
        rd_check("R10 rx overrun", 12'h004, 32'hA);
        bus_wr(12'h008, 32'h2A);
        rd_check("R11 rxo visible", 12'h00C, 32'hA);
        check("R12 rxo lines", irqs(), 32'h1A);
        rd_check("R10 overwritten", 12'h000, 32'h22);
        bus_wr(12'h004, 32'h8);
        rd_check("R5 rxo W1C", 12'h004, 32'h0);
        bus_wr(12'h00C, 32'h2);

        // R9: receiver disabled drops frames
        bus_wr(12'h008, 32'h00);
        send_rx(8'h77);
        rd_check("R9 not full", 12'h004, 32'h0);
        rd_check("R9 buffer kept", 12'h000, 32'h22);

        // R7: invalid divider ignores the line on receive
        bus_wr(12'h010, 32'd8);
        bus_wr(12'h008, 32'h02);
        send_rx(8'h3E);
        rd_check("R7 rx idle", 12'h004, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule